// File: doc/BRIEF.md
# SDRAM Bank Open-Row Tracker

This controller-side block sits between an access requester and the command path of a multi-bank SDRAM (four banks by default). It keeps one state machine per bank. Each machine holds the bank's condition (idle, opening, open or closing), the row that is currently open, a countdown timer and one pending request. Requests arrive with a bank, a row, a column and a direction. The block turns each request into a legal command sequence. An idle bank gets an activate and then the column command. An open bank whose row matches gets the column command alone. An open bank holding a different row gets a precharge, then an activate, then the column command.

Rows stay open after an access. A precharge is issued only when a request misses the open row. Requests enter through a valid/ready handshake. Each bank's pending request slot is handled independently, so work for different banks overlaps. When column commands are ready in several banks, they go out on consecutive cycles. At most one command leaves per cycle, and it is held in an output register. A ready read or write always wins over a pending activate or precharge. Within each class, a rotating pointer picks among the banks.

Top module: `sdr_row_tracker`

## Requirements
- R1: After synchronous reset, every bank is idle with no open row, `cmd_valid` is 0 and `req_ready` is 1 for every bank.
- R2: A read or write to a bank is emitted only while that bank holds the request's row open. It comes at least `TRCD` cycles after the activate that opened the row. With no competing work, it comes exactly `TRCD` cycles after that activate, and the activate appears one cycle after the request is accepted.
- R3: A request whose row matches the open row of an open bank produces only a read or write, one cycle after acceptance, with no activate or precharge.
- R4: A request for a different row in an open bank produces a precharge one cycle after acceptance, then an activate exactly `TRP` cycles after the precharge, then the column command `TRCD` cycles after the activate. An activate is never sent to a bank that is already open.
- R5: At most one command is emitted per cycle. When a read or write is ready in one bank in the same cycle that an activate or precharge is ready in another, the read or write goes first.
- R6: Column commands to different open banks, requested on consecutive cycles, are emitted on consecutive cycles.
- R7: Column commands to the same bank and row, requested on consecutive cycles, are emitted on consecutive cycles.
- R8: For each bank, reads and writes leave in request order. Each carries the request's column on `cmd_addr`, and its opcode follows the request direction: 1 for read, 2 for write. An activate carries the row on `cmd_addr` with opcode 0. A precharge has opcode 3.
- R9: `req_ready` for the bank on `req_bank` is 0 while that bank's slot holds a request that is not being issued as a read or write this cycle. It is 1 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Slot of the addressed bank can take the request |
| req_bank | input | BANK_W | Target bank |
| req_row | input | ROW_W | Target row |
| req_col | input | COL_W | Starting column |
| req_write | input | 1 | 1 = write, 0 = read |
| cmd_valid | output | 1 | A command is present this cycle |
| cmd_op | output | 2 | 0 activate, 1 read, 2 write, 3 precharge |
| cmd_bank | output | BANK_W | Bank the command addresses |
| cmd_addr | output | ADDR_W | Row for activate, column for read/write, 0 for precharge |

## Verification
The bench concentrates on the timing seams. These are the gap between an activate and its column command, and the gap between a precharge and the following activate. A design that counted its timers one cycle short would put a read out before the row is usable. One that counted a cycle long would lose bandwidth, and the exact-gap checks catch both. A row miss is steered so that its activate falls in the same cycle as a row hit in another bank. A design without read/write precedence would delay the hit. Back-to-back requests to one bank and to alternating banks expose a handshake that blocks a slot while its command is still leaving, which would leave bubbles in the column stream. A shadow model of open rows, fed only by the command port, flags any column command to a closed bank or to the wrong row.

// File: rtl/sdr_trk_pkg.sv
package sdr_trk_pkg;

  typedef enum logic [1:0] {
    BK_IDLE    = 2'd0,
    BK_OPENING = 2'd1,
    BK_OPEN    = 2'd2,
    BK_CLOSING = 2'd3
  } bank_st_e;

  typedef enum logic [1:0] {
    OP_ACT = 2'd0,
    OP_RD  = 2'd1,
    OP_WR  = 2'd2,
    OP_PRE = 2'd3
  } cmd_op_e;

  function automatic int max_of(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sdr_bank_ctl.sv
module sdr_bank_ctl
  import sdr_trk_pkg::*;
#(
  parameter int ROW_W = 13,
  parameter int COL_W = 9,
  parameter int TRCD  = 2,
  parameter int TRP   = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [ROW_W-1:0] load_row,
  input  logic [COL_W-1:0] load_col,
  input  logic             load_wr,
  input  logic             gnt_rw,
  input  logic             gnt_ap,
  output logic             want_rw,
  output logic             want_ap,
  output logic             ap_is_act,
  output logic             pend,
  output logic [ROW_W-1:0] slot_row,
  output logic [COL_W-1:0] slot_col,
  output logic             slot_wr
);

  localparam int TMAX = max_of(max_of(TRCD, TRP), 1);
  localparam int TW   = $clog2(TMAX + 1);

  bank_st_e         st;
  logic [TW-1:0]    tmr;
  logic [ROW_W-1:0] open_row;
  logic             row_hit;

  assign row_hit   = (open_row == slot_row);
  assign want_rw   = pend && (st == BK_OPEN) && row_hit;
  assign want_ap   = pend && ((st == BK_IDLE) || ((st == BK_OPEN) && !row_hit));
  assign ap_is_act = (st == BK_IDLE);

  // bank condition and timer
  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= BK_IDLE;
      tmr      <= '0;
      open_row <= '0;
    end else begin
      unique case (st)
        BK_IDLE: begin
          if (gnt_ap) begin
            open_row <= slot_row;
            tmr      <= TW'(max_of(TRCD - 1, 0));
            st       <= (TRCD > 1) ? BK_OPENING : BK_OPEN;
          end
        end
        BK_OPENING: begin
          tmr <= tmr - 1'b1;
          if (tmr <= TW'(1)) st <= BK_OPEN;
        end
        BK_OPEN: begin
          if (gnt_ap) begin
            tmr <= TW'(max_of(TRP - 1, 0));
            st  <= (TRP > 1) ? BK_CLOSING : BK_IDLE;
          end
        end
        BK_CLOSING: begin
          tmr <= tmr - 1'b1;
          if (tmr <= TW'(1)) st <= BK_IDLE;
        end
        default: st <= BK_IDLE;
      endcase
    end
  end

  // single pending request slot
  always_ff @(posedge clk) begin
    if (rst) begin
      pend     <= 1'b0;
      slot_row <= '0;
      slot_col <= '0;
      slot_wr  <= 1'b0;
    end else if (load) begin
      pend     <= 1'b1;
      slot_row <= load_row;
      slot_col <= load_col;
      slot_wr  <= load_wr;
    end else if (gnt_rw) begin
      pend <= 1'b0;
    end
  end

  p_rw_needs_open_row_r2: assert property (@(posedge clk) disable iff (rst)
    gnt_rw |-> (st == BK_OPEN) && (open_row == slot_row));

  p_ap_only_idle_or_miss_r4: assert property (@(posedge clk) disable iff (rst)
    (gnt_ap && st != BK_IDLE) |-> (st == BK_OPEN) && (open_row != slot_row));

  p_grant_needs_pending_r8: assert property (@(posedge clk) disable iff (rst)
    (gnt_rw || gnt_ap) |-> pend);

  p_opening_progress_r2: assert property (@(posedge clk) disable iff (rst)
    (st == BK_OPENING) |=> (st == BK_OPENING) || (st == BK_OPEN));

  p_row_held_r3: assert property (@(posedge clk) disable iff (rst)
    (st == BK_OPEN && !gnt_ap) |=> $stable(open_row) && (st == BK_OPEN));

endmodule

// File: rtl/sdr_cmd_arb.sv
module sdr_cmd_arb #(
  parameter int NB = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [NB-1:0] want_rw,
  input  logic [NB-1:0] want_ap,
  output logic [NB-1:0] gnt_rw,
  output logic [NB-1:0] gnt_ap
);

  localparam int PW = (NB > 1) ? $clog2(NB) : 1;

  logic [PW-1:0] ptr;
  logic [PW-1:0] win;
  logic          found;

  // column commands first, then activate/precharge, each rotating from ptr
  always_comb begin
    gnt_rw = '0;
    gnt_ap = '0;
    win    = '0;
    found  = 1'b0;
    for (int k = 0; k < NB; k++) begin
      int idx;
      idx = (int'(ptr) + k) % NB;
      if (!found && want_rw[idx]) begin
        gnt_rw[idx] = 1'b1;
        win         = PW'(idx);
        found       = 1'b1;
      end
    end
    for (int k = 0; k < NB; k++) begin
      int idx;
      idx = (int'(ptr) + k) % NB;
      if (!found && want_ap[idx]) begin
        gnt_ap[idx] = 1'b1;
        win         = PW'(idx);
        found       = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)        ptr <= '0;
    else if (found) ptr <= PW'((int'(win) + 1) % NB);
  end

  p_one_command_r5: assert property (@(posedge clk) disable iff (rst)
    $onehot0({gnt_rw, gnt_ap}));

  p_rw_precedence_r5: assert property (@(posedge clk) disable iff (rst)
    (|want_rw) |-> (|gnt_rw));

  p_grant_was_wanted_r5: assert property (@(posedge clk) disable iff (rst)
    ((gnt_rw & ~want_rw) == '0) && ((gnt_ap & ~want_ap) == '0));

endmodule

// File: rtl/sdr_row_tracker.sv
module sdr_row_tracker
  import sdr_trk_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int ROW_W     = 13,
  parameter int COL_W     = 9,
  parameter int TRCD      = 2,
  parameter int TRP       = 2,
  localparam int BANK_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
  localparam int ADDR_W   = (ROW_W > COL_W) ? ROW_W : COL_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [BANK_W-1:0] req_bank,
  input  logic [ROW_W-1:0]  req_row,
  input  logic [COL_W-1:0]  req_col,
  input  logic              req_write,
  output logic              cmd_valid,
  output logic [1:0]        cmd_op,
  output logic [BANK_W-1:0] cmd_bank,
  output logic [ADDR_W-1:0] cmd_addr
);

  logic [NUM_BANKS-1:0] want_rw, want_ap, gnt_rw, gnt_ap, is_act, pend, load, s_wr;
  logic [ROW_W-1:0]     s_row [NUM_BANKS];
  logic [COL_W-1:0]     s_col [NUM_BANKS];

  assign req_ready = !pend[req_bank] || gnt_rw[req_bank];

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    assign load[b] = req_valid && req_ready && (req_bank == BANK_W'(b));

    sdr_bank_ctl #(
      .ROW_W(ROW_W), .COL_W(COL_W), .TRCD(TRCD), .TRP(TRP)
    ) u_bank (
      .clk      (clk),
      .rst      (rst),
      .load     (load[b]),
      .load_row (req_row),
      .load_col (req_col),
      .load_wr  (req_write),
      .gnt_rw   (gnt_rw[b]),
      .gnt_ap   (gnt_ap[b]),
      .want_rw  (want_rw[b]),
      .want_ap  (want_ap[b]),
      .ap_is_act(is_act[b]),
      .pend     (pend[b]),
      .slot_row (s_row[b]),
      .slot_col (s_col[b]),
      .slot_wr  (s_wr[b])
    );
  end

  sdr_cmd_arb #(.NB(NUM_BANKS)) u_arb (
    .clk    (clk),
    .rst    (rst),
    .want_rw(want_rw),
    .want_ap(want_ap),
    .gnt_rw (gnt_rw),
    .gnt_ap (gnt_ap)
  );

  cmd_op_e           sel_op;
  logic [BANK_W-1:0] sel_bank;
  logic [ADDR_W-1:0] sel_addr;

  always_comb begin
    sel_op   = OP_ACT;
    sel_bank = '0;
    sel_addr = '0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (gnt_rw[b]) begin
        sel_op   = s_wr[b] ? OP_WR : OP_RD;
        sel_bank = BANK_W'(b);
        sel_addr = ADDR_W'(s_col[b]);
      end else if (gnt_ap[b]) begin
        sel_op   = is_act[b] ? OP_ACT : OP_PRE;
        sel_bank = BANK_W'(b);
        sel_addr = is_act[b] ? ADDR_W'(s_row[b]) : '0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_valid <= 1'b0;
      cmd_op    <= 2'd0;
      cmd_bank  <= '0;
      cmd_addr  <= '0;
    end else begin
      cmd_valid <= |{gnt_rw, gnt_ap};
      cmd_op    <= sel_op;
      cmd_bank  <= sel_bank;
      cmd_addr  <= sel_addr;
    end
  end

  p_blocked_slot_r9: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_ready) |-> pend[req_bank]);

  p_accept_fills_slot_r9: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> pend[$past(req_bank)]);

endmodule

// File: tb/tb_sdr_row_tracker.sv
module tb_sdr_row_tracker;

  localparam int NB = 4, ROW_W = 13, COL_W = 9, TRCD = 2, TRP = 2;
  localparam int BANK_W = 2, ADDR_W = 13;

  // {bank, row, col, write}
  localparam logic [24:0] VEC [16] = '{
    {2'd0, 13'd10, 9'd1,  1'b0}, {2'd1, 13'd20, 9'd2,  1'b1},
    {2'd0, 13'd10, 9'd3,  1'b1}, {2'd2, 13'd30, 9'd4,  1'b0},
    {2'd0, 13'd11, 9'd5,  1'b0}, {2'd1, 13'd20, 9'd6,  1'b0},
    {2'd3, 13'd40, 9'd7,  1'b1}, {2'd3, 13'd40, 9'd8,  1'b0},
    {2'd2, 13'd31, 9'd9,  1'b1}, {2'd1, 13'd21, 9'd10, 1'b0},
    {2'd0, 13'd11, 9'd11, 1'b1}, {2'd2, 13'd31, 9'd12, 1'b0},
    {2'd3, 13'd41, 9'd13, 1'b0}, {2'd1, 13'd21, 9'd14, 1'b1},
    {2'd0, 13'd12, 9'd15, 1'b0}, {2'd3, 13'd41, 9'd16, 1'b1}
  };

  logic clk = 0, rst = 1;
  logic req_valid = 0, req_write = 0;
  logic req_ready;
  logic [BANK_W-1:0] req_bank = '0;
  logic [ROW_W-1:0]  req_row = '0;
  logic [COL_W-1:0]  req_col = '0;
  logic cmd_valid;
  logic [1:0] cmd_op;
  logic [BANK_W-1:0] cmd_bank;
  logic [ADDR_W-1:0] cmd_addr;

  sdr_row_tracker dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_bank(req_bank), .req_row(req_row), .req_col(req_col), .req_write(req_write),
    .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_bank(cmd_bank), .cmd_addr(cmd_addr)
  );

  always #5 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int nchk = 0, nfail = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string r, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", r, act, exp, cyc);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
    end
  endtask

  // shadow model driven only by the command port
  bit  bk_open [NB];
  int  bk_row [NB];
  int  last_act [NB], last_pre [NB], last_rw [NB];
  logic [22:0] exp_q [NB][$];
  int  rw_log [256];
  int  rw_n = 0;

  initial for (int b = 0; b < NB; b++) begin
    bk_open[b] = 0; bk_row[b] = 0;
    last_act[b] = -100; last_pre[b] = -100; last_rw[b] = -100;
  end

  always @(negedge clk) begin
    if (!rst && cmd_valid) begin
      int b;
      logic [22:0] e;
      b = int'(cmd_bank);
      case (cmd_op)
        2'd0: begin
          chk(!bk_open[b], "R4 act to open bank", 1, 0);
          chk(cyc - last_pre[b] >= TRP, "R4 pre-to-act gap", cyc - last_pre[b], TRP);
          chk(exp_q[b].size() > 0 && int'(exp_q[b][0][22:10]) == int'(cmd_addr),
              "R2 act row", int'(cmd_addr), exp_q[b].size() > 0 ? int'(exp_q[b][0][22:10]) : -1);
          bk_open[b] = 1; bk_row[b] = int'(cmd_addr); last_act[b] = cyc;
        end
        2'd1, 2'd2: begin
          chk(exp_q[b].size() > 0, "R8 unexpected column cmd", 1, 0);
          if (exp_q[b].size() > 0) begin
            e = exp_q[b].pop_front();
            chk(bk_open[b] && bk_row[b] == int'(e[22:10]), "R2 row open for rw",
                bk_open[b] ? bk_row[b] : -1, int'(e[22:10]));
            chk(cyc - last_act[b] >= TRCD, "R2 act-to-rw gap", cyc - last_act[b], TRCD);
            chk(int'(cmd_addr) == int'(e[9:1]), "R8 column", int'(cmd_addr), int'(e[9:1]));
            chk(int'(cmd_op) == (e[0] ? 2 : 1), "R8 opcode", int'(cmd_op), e[0] ? 2 : 1);
          end
          last_rw[b] = cyc;
          if (rw_n < 256) rw_log[rw_n] = cyc;
          rw_n++;
        end
        default: begin
          chk(bk_open[b], "R4 precharge of closed bank", 0, 1);
          chk(exp_q[b].size() > 0 && int'(exp_q[b][0][22:10]) != bk_row[b],
              "R4 precharge only on miss", bk_row[b], -1);
          bk_open[b] = 0; last_pre[b] = cyc;
        end
      endcase
    end
  end

  task automatic send(input int b, input int row, input int col, input bit wr);
    req_valid = 1; req_bank = BANK_W'(b); req_row = ROW_W'(row);
    req_col = COL_W'(col); req_write = wr;
    #1;
    while (!req_ready) begin @(negedge clk); #1; end
    exp_q[b].push_back({ROW_W'(row), COL_W'(col), wr});
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    req_valid = 0;
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    chk(0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    int acc, base, nact;
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    chk(cmd_valid == 0, "R1 cmd_valid after reset", cmd_valid, 0);
    #1;
    chk(req_ready == 1, "R1 ready after reset", req_ready, 1);

    // R9 slot blocked while bank 3 is still opening
    send(3, 11, 1, 0);
    acc = cyc;
    req_valid = 0; req_bank = 2'd3; #1;
    chk(req_ready == 0, "R9 busy slot not ready", req_ready, 0);
    req_bank = 2'd2; #1;
    chk(req_ready == 1, "R9 free slot ready", req_ready, 1);
    idle(8);
    chk(last_act[3] == acc + 1, "R2 act one cycle after accept", last_act[3], acc + 1);
    chk(last_rw[3] - last_act[3] == TRCD, "R2 exact act-to-rw gap", last_rw[3] - last_act[3], TRCD);

    // table of mixed hits, misses and banks
    for (int i = 0; i < 16; i++)
      send(int'(VEC[i][24:23]), int'(VEC[i][22:10]), int'(VEC[i][9:1]), VEC[i][0]);
    idle(40);
    for (int b = 0; b < NB; b++)
      chk(exp_q[b].size() == 0, "R8 all requests issued", exp_q[b].size(), 0);

    // R3 row hit
    send(0, 100, 0, 0); idle(10);
    nact = last_act[0];
    send(0, 100, 5, 1); acc = cyc; idle(6);
    chk(last_rw[0] == acc + 1, "R3 hit issues next cycle", last_rw[0], acc + 1);
    chk(last_act[0] == nact, "R3 no activate on hit", last_act[0], nact);

    // R4 row miss
    send(0, 200, 6, 0); acc = cyc; idle(10);
    chk(last_pre[0] == acc + 1, "R4 precharge after accept", last_pre[0], acc + 1);
    chk(last_act[0] - last_pre[0] == TRP, "R4 exact pre-to-act gap", last_act[0] - last_pre[0], TRP);
    chk(last_rw[0] - last_act[0] == TRCD, "R4 exact act-to-rw gap", last_rw[0] - last_act[0], TRCD);

    // R5 column command beats a simultaneous activate
    send(2, 50, 0, 0); idle(10);
    send(2, 60, 1, 0); idle(1);
    send(0, 200, 7, 0); idle(10);
    chk(last_rw[0] == last_pre[2] + 2, "R5 rw issued first", last_rw[0], last_pre[2] + 2);
    chk(last_act[2] == last_rw[0] + 1, "R5 activate deferred", last_act[2], last_rw[0] + 1);

    // R6 alternating open banks
    send(1, 7, 0, 0); idle(10);
    base = rw_n;
    send(0, 200, 1, 0); send(1, 7, 2, 1); send(0, 200, 3, 0); send(1, 7, 4, 0);
    idle(8);
    chk(rw_n == base + 4, "R6 four column cmds", rw_n - base, 4);
    for (int k = 1; k < 4; k++)
      chk(rw_log[base + k] == rw_log[base + k - 1] + 1, "R6 back to back",
          rw_log[base + k] - rw_log[base + k - 1], 1);

    // R7 same bank, same row
    base = rw_n;
    for (int k = 0; k < 4; k++) send(0, 200, 20 + k, k[0]);
    idle(8);
    chk(rw_n == base + 4, "R7 four column cmds", rw_n - base, 4);
    for (int k = 1; k < 4; k++)
      chk(rw_log[base + k] == rw_log[base + k - 1] + 1, "R7 back to back",
          rw_log[base + k] - rw_log[base + k - 1], 1);

    for (int b = 0; b < NB; b++)
      chk(exp_q[b].size() == 0, "R8 queues drained", exp_q[b].size(), 0);
    finish_run();
  end

endmodule